// File: doc/BRIEF.md
# Debug Serial Port Slave

This block is the target side of a full-duplex synchronous serial link for background debugging. The external host is the master: it drives the serial clock and sends one 17-bit word per transfer. While that word arrives, the block sends back a 17-bit response word. Each word carries a status/control flag in its top bit, followed by 16 data bits. Both words travel most significant bit first.

The serial clock and data are not used as clocks. They are sampled into the system clock domain. Each input is captured on a rising system-clock edge and handed to the logic on the following falling edge. The block then detects the serial clock edges from the sampled signal.

On the parallel side, a received word appears with a one-cycle valid strobe. The command logic loads a response by giving a response type and, for plain data, a 16-bit value. The block turns the type into the fixed flag-and-data pattern. If nothing has been loaded when a transfer starts, the block answers "not ready".

Top module: `dbg_serial_slave`

## Requirements
- R1: After reset, `sdo_o` is 1 (the first bit of the not-ready pattern) and `rx_valid_o` is 0.
- R2: The block captures one serial-data bit on each rising serial-clock edge. After the 17th captured bit, `rx_data_o` holds the last 16 captured bits (first captured at bit 15) and `rx_valid_o` is high for exactly one system-clock cycle.
- R3: The first bit of a received word, the host's flag, has no effect: `rx_data_o` and `rx_valid_o` do not depend on its value.
- R4: The response goes out most significant bit first: the flag, then data bit 15 down to data bit 0. The first bit is present on `sdo_o` before the first rising edge. Within a word, `sdo_o` changes only after a falling serial-clock edge.
- R5: `tx_type_i` selects the response word. Code 0 sends flag 0 with `tx_data_i`. Code 1 sends flag 0 with FFFF (command complete). Code 2 sends flag 1 with 0000 (not ready). Code 3 sends flag 1 with 0001 (bus error). Codes 4 to 7 send flag 1 with FFFF (illegal command).
- R6: If no response has been loaded since the previous word completed, the next transfer sends the not-ready pattern: flag 1, data 0000.
- R7: A response loaded while no word is in progress is sent in the next transfer. A response loaded during a transfer does not change the word being sent. It is sent in the following transfer.
- R8: The bit counter counts from 0 to 16 and returns to 0 when a word completes. Reset in the middle of a word clears the counter, so the next transfer is received whole.
- R9: Transfers work at any serial clock rate up to half the system clock, including the fastest rate, where the clock is high for one system cycle and low for one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| rx_data_o | output | 16 | Data bits of the last received word |
| rx_valid_o | output | 1 | One-cycle strobe when a word completes |
| tx_load_i | input | 1 | Load a response, one cycle |
| tx_type_i | input | 3 | Response type code |
| tx_data_i | input | 16 | Response data for type code 0 |

## Verification
The checker watches four things on every cycle:
- the bit counter stays within range;
- the valid strobe follows the 17th rising edge and lasts one cycle;
- `sdo_o` holds steady inside a word except after a falling edge;
- the not-ready flag is loaded when no response is waiting.

Only the bench's transfers can show the rest:
- the full bit order in both directions;
- each response encoding;
- that the host flag is ignored;
- the load timing during a transfer;
- recovery from reset mid-word;
- operation at the fastest serial clock rate.

// File: rtl/dbg_serial_slave.sv
module dbg_serial_slave #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  input  logic          tx_load_i,
  input  logic [2:0]    tx_type_i,
  input  logic [DW-1:0] tx_data_i
);
  localparam int WW = DW + 1;
  localparam int CW = $clog2(WW);
  localparam logic [CW-1:0] LAST = CW'(WW - 1);
  localparam logic [WW-1:0] NOT_READY = {1'b1, {DW{1'b0}}};

  function automatic logic [WW-1:0] encode(logic [2:0] t, logic [DW-1:0] d);
    case (t)
      3'd0:    return {1'b0, d};
      3'd1:    return {1'b0, {DW{1'b1}}};
      3'd2:    return NOT_READY;
      3'd3:    return {1'b1, DW'(1)};
      default: return {1'b1, {DW{1'b1}}};
    endcase
  endfunction

  logic [1:0] smp_q, syn_q;
  logic       sclk_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) smp_q <= '0;
    else        smp_q <= {sclk_i, sdi_i};

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) syn_q <= '0;
    else        syn_q <= smp_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= syn_q[1];

  wire sclk_rise = syn_q[1] & ~sclk_d;
  wire sclk_fall = ~syn_q[1] & sclk_d;

  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_sh;
  logic [WW-1:0] tx_sh, pend;
  logic          pend_v;

  wire done = sclk_rise && (bit_cnt == LAST);
  wire idle = (bit_cnt == '0) && !sclk_rise;
  wire [WW-1:0] load_word = encode(tx_type_i, tx_data_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= done;
      if (sclk_rise) begin
        rx_sh   <= {rx_sh[DW-2:0], syn_q[0]};
        bit_cnt <= done ? '0 : bit_cnt + 1'b1;
      end
      if (done) rx_data_o <= {rx_sh[DW-2:0], syn_q[0]};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh  <= NOT_READY;
      pend   <= '0;
      pend_v <= 1'b0;
    end else if (done) begin
      tx_sh  <= tx_load_i ? load_word : (pend_v ? pend : NOT_READY);
      pend_v <= 1'b0;
    end else if (tx_load_i && idle) begin
      tx_sh  <= load_word;
    end else begin
      if (sclk_fall && bit_cnt != '0) tx_sh <= {tx_sh[WW-2:0], 1'b0};
      if (tx_load_i) begin
        pend   <= load_word;
        pend_v <= 1'b1;
      end
    end

  assign sdo_o = tx_sh[WW-1];
endmodule

// File: rtl/dbg_serial_slave_chk.sv
module dbg_serial_slave_chk #(
  parameter int CW = 5,
  parameter int LAST = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk_rise,
  input logic          sclk_fall,
  input logic [CW-1:0] bit_cnt,
  input logic          sdo_o,
  input logic          rx_valid_o,
  input logic          pend_v,
  input logic          tx_load_i
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(LAST)); // R8

  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> ($past(sclk_rise) && $past(bit_cnt) == CW'(LAST))); // R2

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o); // R2

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != '0 && !sclk_fall && !sclk_rise) |=> $stable(sdo_o)); // R4

  AST_NOT_READY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && bit_cnt == CW'(LAST) && !pend_v && !tx_load_i) |=> sdo_o); // R6
endmodule

bind dbg_serial_slave dbg_serial_slave_chk #(.CW(CW), .LAST(WW - 1)) chk_i (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .bit_cnt(bit_cnt), .sdo_o(sdo_o), .rx_valid_o(rx_valid_o),
  .pend_v(pend_v), .tx_load_i(tx_load_i));

// File: tb/dbg_serial_slave_tb.sv
`timescale 1ns/1ps
module dbg_serial_slave_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic tx_load = 1'b0;
  logic [2:0] tx_type = '0;
  logic [15:0] tx_data = '0;
  logic sdo, rx_valid;
  logic [15:0] rx_data;
  int n_chk = 0, n_fail = 0, n_valid = 0;
  logic [15:0] last_rx = '0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dbg_serial_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .tx_load_i(tx_load),
    .tx_type_i(tx_type), .tx_data_i(tx_data));

  always @(negedge clk) if (rx_valid) begin n_valid++; last_rx = rx_data; end

  // fields: type[35:33], response data[32:17], host word[16:0]
  localparam logic [35:0] VEC [6] = '{
    {3'd0, 16'h1234, 17'h0_5A5A},
    {3'd1, 16'h0000, 17'h1_C3C3},
    {3'd2, 16'hFFFF, 17'h0_0001},
    {3'd3, 16'h8000, 17'h1_8000},
    {3'd4, 16'h0F0F, 17'h0_FFFF},
    {3'd7, 16'h2222, 17'h1_0000}
  };

  function automatic logic [16:0] expect_word(logic [2:0] t, logic [15:0] d);
    case (t)
      3'd0: return {1'b0, d};
      3'd1: return 17'h0_FFFF;
      3'd2: return 17'h1_0000;
      3'd3: return 17'h1_0001;
      default: return 17'h1_FFFF;
    endcase
  endfunction

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [2:0] t, input logic [15:0] d);
    tx_type = t; tx_data = d; tx_load = 1'b1;
    step(1);
    tx_load = 1'b0;
  endtask

  task automatic xfer(input logic [16:0] w, input int h, output logic [16:0] got);
    for (int i = 16; i >= 0; i--) begin
      sdi = w[i];
      step(h);
      got[i] = sdo;
      sclk = 1'b1;
      step(h);
      sclk = 1'b0;
    end
    step(8);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [16:0] got;
    int nv;
    step(3);
    check("R1 sdo", {16'h0, sdo}, 17'h1);
    check("R1 valid", {16'h0, rx_valid}, 17'h0);
    rst_n = 1'b1;
    step(3);

    for (int k = 0; k < 6; k++) begin
      nv = n_valid;
      load(VEC[k][35:33], VEC[k][32:17]);
      step(2);
      xfer(VEC[k][16:0], 4, got);
      check("R4 R5 response", got, expect_word(VEC[k][35:33], VEC[k][32:17]));
      check("R2 R3 rx data", {1'b0, last_rx}, {1'b0, VEC[k][15:0]});
      check("R2 one strobe", 17'(n_valid - nv), 17'd1);
    end

    xfer(17'h0_1357, 4, got);
    check("R6 no load", got, 17'h1_0000);

    fork
      xfer(17'h1_2468, 4, got);
      begin step(40); load(3'd0, 16'hA5A5); end
    join
    check("R7 mid load current", got, 17'h1_0000);
    check("R3 host flag set", {1'b0, last_rx}, 17'h0_2468);
    xfer(17'h0_0000, 4, got);
    check("R7 mid load next", got, 17'h0_A5A5);

    for (int i = 0; i < 5; i++) begin
      sdi = i[0]; step(4); sclk = 1'b1; step(4); sclk = 1'b0;
    end
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
    nv = n_valid;
    load(3'd1, 16'h0);
    step(2);
    xfer(17'h0_BEEF, 4, got);
    check("R8 reset mid word rx", {1'b0, last_rx}, 17'h0_BEEF);
    check("R8 reset mid word tx", got, 17'h0_FFFF);
    check("R8 one word", 17'(n_valid - nv), 17'd1);

    nv = n_valid;
    xfer(17'h0_6C39, 1, got);
    check("R9 fast rx", {1'b0, last_rx}, 17'h0_6C39);
    check("R9 fast strobe", 17'(n_valid - nv), 17'd1);

    summary();
  end
endmodule